// File: doc/BRIEF.md
# SDRAM Column Burst Sequencer

This block drives a single column burst into a 16-bit single-data-rate SDRAM whose row has already been opened. A user request names the bank, the starting column, the direction, whether the burst is a fixed-length one or a full-page one, and the CAS latency. The sequencer then puts the column command on the command pins, streams write data or captures read data, and asserts the per-byte masks in the cycles where the memory expects them. When the burst has finished, it pulses `done`. For writes, this pulse waits until the write-recovery interval has passed.

During the burst, `beat_req` tells the user which cycles need a beat. For writes, the user supplies data and mask in the same cycle. For reads, the user supplies only the mask, two cycles ahead of the matching data. Read beats come back on `rd_valid`/`rd_data`. Each beat also carries a per-byte masked flag, so blanked bytes are reported rather than dropped.

Opening rows, refresh, precharge and mode-register set-up are handled elsewhere. Their result arrives on `bank_active`. The reset is asynchronous and active low, and its release is expected to be synchronised upstream.

Top module: `sdr_burst_seq`

## Requirements
- R1: `req_ready` is high only while the sequencer is idle and `bank_active` is high. While `bank_active` is low, no READ or WRITE appears on `sd_cmd_n`.
- R2: `sd_cmd_n` is {cs_n, ras_n, cas_n, we_n}: READ 0101, WRITE 0100, BURST STOP 0110, NOP 0111. READ or WRITE is issued in the cycle after acceptance (call it c0) with `sd_ba` = the bank and `sd_addr` = the column zero-extended, so bit 10 is low and no auto-precharge is requested. All other cycles carry NOP or BURST STOP with `sd_addr` zero.
- R3: Read beat i is sampled from `sd_dq_in` during cycle c0+CL+i and appears on `rd_data` with `rd_valid` in cycle c0+CL+i+1. Beats come back in burst order.
- R4: CL is 3 when `cfg_cas3` is high at acceptance, otherwise 2.
- R5: On reads, `beat_req` is high in cycles c0+CL-2+i, and `sd_dqm` follows `beat_mask` there (bit 0 = low byte, bit 1 = high byte). `rd_masked` of beat i repeats that mask, and masked bytes of `rd_data` read as zero.
- R6: `sd_dq_oe` is never high during a read operation, nor in any cycle in which the memory drives DQ.
- R7: On writes, `beat_req` and `sd_dq_oe` are high exactly in cycles c0 to c0+N-1, with `sd_dq_out` = `beat_wdata`. The first beat shares its cycle with the WRITE command.
- R8: On writes, `sd_dqm` = `beat_mask` in the same cycle as the data beat, and a masked byte is left unchanged in the memory.
- R9: A fixed burst has N = BURST_LEN (default 4) beats and issues no BURST STOP.
- R10: A full-page burst has N = `req_len` beats (1 to PAGE_COLS) and issues BURST STOP in cycle c0+N.
- R11: For a write, `done` pulses in cycle c0+N+TWR (TWR defaults to 2), so at least TWR cycles follow the last data beat.
- R12: For a read, `done` pulses in cycle c0+CL+N, together with the last `rd_valid`. The next request can be accepted only after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bank_active | input | 1 | Target bank has an open row |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request taken at this edge when valid |
| req_write | input | 1 | 1 = write burst, 0 = read burst |
| req_bank | input | BA_W | Bank select |
| req_col | input | COL_W | Starting column |
| req_full_page | input | 1 | Full-page burst ended by BURST STOP |
| req_len | input | clog2(PAGE_COLS+1) | Beats of a full-page burst |
| cfg_cas3 | input | 1 | CAS latency 3 when high, 2 when low |
| beat_req | output | 1 | Beat wanted from user this cycle |
| beat_wdata | input | DQ_W | Write data for the current beat |
| beat_mask | input | DQ_W/8 | Byte mask for the current beat |
| rd_valid | output | 1 | Read beat valid |
| rd_data | output | DQ_W | Read data, masked bytes zero |
| rd_masked | output | DQ_W/8 | Per-byte mask applied to this beat |
| done | output | 1 | Operation complete pulse |
| sd_cmd_n | output | 4 | {cs_n, ras_n, cas_n, we_n} |
| sd_ba | output | BA_W | Bank address pins |
| sd_addr | output | ADDR_W | Address pins |
| sd_dqm | output | DQ_W/8 | Byte mask pins |
| sd_dq_out | output | DQ_W | DQ drive value |
| sd_dq_oe | output | 1 | DQ output enable |
| sd_dq_in | input | DQ_W | DQ sampled value |

## Verification
The assertions assume the following:
- `bank_active` stays high for the whole of any operation it was high for at acceptance.
- A full-page request never carries a zero or oversized length.
- The memory has been programmed with the same burst mode and CAS latency as the request.

The stimulus keeps within these assumptions by holding `bank_active` high across each burst and drawing full-page lengths from 1 to 7. It also sets the bench's memory model to the same fixed or full-page mode and latency before each request. `bank_active` is driven low only while the sequencer is idle, and a request is offered during that time.

// File: rtl/sdr_burst_pkg.sv
package sdr_burst_pkg;
  // Command pin code, bit order {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_WRITE = 4'b0100,
    CMD_READ  = 4'b0101,
    CMD_BSTOP = 4'b0110,
    CMD_NOP   = 4'b0111
  } sdr_cmd_e;
endpackage

// File: rtl/burst_cyc_cnt.sv
module burst_cyc_cnt #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  output logic [W-1:0] cnt
);
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt;
    if (clr)     cnt_d = '0;
    else if (en) cnt_d = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end
endmodule

// File: rtl/rd_capture_pipe.sv
// Carries the read-side byte mask two cycles, so it lines up with the data
// it blanked, then registers data, mask and strobe together.
module rd_capture_pipe #(
  parameter int DQ_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DQ_W/8-1:0] push_mask,
  input  logic [DQ_W-1:0]   dq_in,
  output logic              rd_valid,
  output logic [DQ_W-1:0]   rd_data,
  output logic [DQ_W/8-1:0] rd_masked
);
  localparam int NB = DQ_W / 8;

  logic          s1_v, s2_v;
  logic [NB-1:0] s1_m, s2_m;
  logic [DQ_W-1:0] cap_d;

  for (genvar b = 0; b < NB; b++) begin : g_byte
    assign cap_d[b*8 +: 8] = s2_m[b] ? 8'h00 : dq_in[b*8 +: 8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v      <= 1'b0;
      s2_v      <= 1'b0;
      s1_m      <= '0;
      s2_m      <= '0;
      rd_valid  <= 1'b0;
      rd_data   <= '0;
      rd_masked <= '0;
    end else begin
      s1_v     <= push;
      s2_v     <= s1_v;
      rd_valid <= s2_v;
      if (push) s1_m <= push_mask;
      if (s1_v) s2_m <= s1_m;
      if (s2_v) begin
        rd_data   <= cap_d;
        rd_masked <= s2_m;
      end
    end
  end
endmodule

// File: rtl/sdr_burst_seq.sv
module sdr_burst_seq
  import sdr_burst_pkg::*;
#(
  parameter int DQ_W      = 16,
  parameter int ADDR_W    = 12,
  parameter int COL_W     = 8,
  parameter int BA_W      = 2,
  parameter int BURST_LEN = 4,
  parameter int PAGE_COLS = 256,
  parameter int TWR       = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           bank_active,
  input  logic                           req_valid,
  output logic                           req_ready,
  input  logic                           req_write,
  input  logic [BA_W-1:0]                req_bank,
  input  logic [COL_W-1:0]               req_col,
  input  logic                           req_full_page,
  input  logic [$clog2(PAGE_COLS+1)-1:0] req_len,
  input  logic                           cfg_cas3,
  output logic                           beat_req,
  input  logic [DQ_W-1:0]                beat_wdata,
  input  logic [DQ_W/8-1:0]              beat_mask,
  output logic                           rd_valid,
  output logic [DQ_W-1:0]                rd_data,
  output logic [DQ_W/8-1:0]              rd_masked,
  output logic                           done,
  output logic [3:0]                     sd_cmd_n,
  output logic [BA_W-1:0]                sd_ba,
  output logic [ADDR_W-1:0]              sd_addr,
  output logic [DQ_W/8-1:0]              sd_dqm,
  output logic [DQ_W-1:0]                sd_dq_out,
  output logic                           sd_dq_oe,
  input  logic [DQ_W-1:0]                sd_dq_in
);
  localparam int NB    = DQ_W / 8;
  localparam int LEN_W = $clog2(PAGE_COLS + 1);
  localparam int CYC_W = $clog2(PAGE_COLS + TWR + 5);

  // operation registers
  logic             busy_q, busy_d, load;
  logic             op_wr, op_full, op_cl3;
  logic [LEN_W-1:0] op_len;
  logic [COL_W-1:0] op_col;
  logic [BA_W-1:0]  op_ba;
  logic [CYC_W-1:0] cyc;

  // derived per-operation timing
  logic [CYC_W-1:0] beats_c, cl_c, last_c, rwin_lo, rwin_hi;
  logic             rd_push;
  sdr_cmd_e         cmd_c;

  assign req_ready = !busy_q && bank_active;

  always_comb begin
    beats_c = op_full ? CYC_W'(op_len) : CYC_W'(BURST_LEN);
    cl_c    = op_cl3 ? CYC_W'(3) : CYC_W'(2);
    rwin_lo = cl_c - CYC_W'(2);
    rwin_hi = rwin_lo + beats_c;
    last_c  = op_wr ? beats_c + CYC_W'(TWR) : beats_c + cl_c;
  end

  assign done = busy_q && (cyc == last_c);

  always_comb begin
    busy_d = busy_q;
    load   = 1'b0;
    if (!busy_q) begin
      if (req_valid && req_ready) begin
        busy_d = 1'b1;
        load   = 1'b1;
      end
    end else if (done) begin
      busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      op_wr   <= 1'b0;
      op_full <= 1'b0;
      op_cl3  <= 1'b0;
      op_len  <= '0;
      op_col  <= '0;
      op_ba   <= '0;
    end else begin
      busy_q <= busy_d;
      if (load) begin
        op_wr   <= req_write;
        op_full <= req_full_page;
        op_cl3  <= cfg_cas3;
        op_len  <= req_len;
        op_col  <= req_col;
        op_ba   <= req_bank;
      end
    end
  end

  burst_cyc_cnt #(.W(CYC_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (load),
    .en    (busy_q),
    .cnt   (cyc)
  );

  // command and address pins
  always_comb begin
    cmd_c   = CMD_NOP;
    sd_addr = '0;
    sd_ba   = '0;
    if (busy_q && cyc == '0) begin
      cmd_c   = op_wr ? CMD_WRITE : CMD_READ;
      sd_addr = ADDR_W'(op_col);
      sd_ba   = op_ba;
    end else if (busy_q && op_full && cyc == beats_c) begin
      cmd_c = CMD_BSTOP;
    end
  end
  assign sd_cmd_n = cmd_c;

  // beat window: data beats on writes, mask slots on reads
  always_comb begin
    if (op_wr) beat_req = busy_q && (cyc < beats_c);
    else       beat_req = busy_q && (cyc >= rwin_lo) && (cyc < rwin_hi);
  end

  assign sd_dq_oe  = beat_req && op_wr;
  assign sd_dq_out = sd_dq_oe ? beat_wdata : '0;
  assign sd_dqm    = beat_req ? beat_mask : '0;
  assign rd_push   = beat_req && !op_wr;

  rd_capture_pipe #(.DQ_W(DQ_W)) u_rdpipe (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (rd_push),
    .push_mask (sd_dqm),
    .dq_in     (sd_dq_in),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .rd_masked (rd_masked)
  );

  // ---------------- assertions ----------------
  p_bank_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !bank_active && !busy_q |=> !(sd_cmd_n == CMD_READ || sd_cmd_n == CMD_WRITE));

  p_single_address_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sd_cmd_n == CMD_READ || sd_cmd_n == CMD_WRITE)
    |=> (sd_cmd_n == CMD_NOP || sd_cmd_n == CMD_BSTOP) && sd_addr == '0);

  p_mask_reaches_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_push |-> ##3 rd_valid);

  p_no_drive_on_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !sd_dq_oe);

  p_stop_only_full_page_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sd_cmd_n == CMD_BSTOP |-> op_full && !sd_dq_oe);

  p_len_legal_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_full_page
    |-> req_len != '0 && int'(req_len) <= PAGE_COLS);

  p_recovery_gap_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done && op_wr |-> !sd_dq_oe && !$past(sd_dq_oe));

  p_read_done_last_beat_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done && !op_wr |-> rd_valid);
endmodule

// File: tb/sdr_burst_seq_tb.sv
`timescale 1ns/1ps
module sdr_burst_seq_tb;
  import sdr_burst_pkg::*;

  localparam int BL  = 4;
  localparam int TWR = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bank_active = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [1:0]  req_bank = '0;
  logic [7:0]  req_col = '0;
  logic        req_full_page = 1'b0;
  logic [8:0]  req_len = 9'd1;
  logic        cfg_cas3 = 1'b0;
  logic        beat_req;
  logic [15:0] beat_wdata;
  logic [1:0]  beat_mask;
  logic        rd_valid;
  logic [15:0] rd_data;
  logic [1:0]  rd_masked;
  logic        done;
  logic [3:0]  sd_cmd_n;
  logic [1:0]  sd_ba;
  logic [11:0] sd_addr;
  logic [1:0]  sd_dqm;
  logic [15:0] sd_dq_out;
  logic        sd_dq_oe;
  logic [15:0] sd_dq_in = 16'h5A5A;

  always #2.5 clk = ~clk;

  sdr_burst_seq u_dut (
    .clk(clk), .rst_n(rst_n), .bank_active(bank_active),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_bank(req_bank), .req_col(req_col), .req_full_page(req_full_page),
    .req_len(req_len), .cfg_cas3(cfg_cas3), .beat_req(beat_req),
    .beat_wdata(beat_wdata), .beat_mask(beat_mask), .rd_valid(rd_valid),
    .rd_data(rd_data), .rd_masked(rd_masked), .done(done),
    .sd_cmd_n(sd_cmd_n), .sd_ba(sd_ba), .sd_addr(sd_addr), .sd_dqm(sd_dqm),
    .sd_dq_out(sd_dq_out), .sd_dq_oe(sd_dq_oe), .sd_dq_in(sd_dq_in)
  );

  int vectors = 0, miscompares = 0;
  int cnt = 0;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // ---------------- memory model ----------------
  logic [15:0] mem [256];
  logic [15:0] ref_mem [256];
  bit          model_full = 0;
  int          model_cl = 2;
  logic [15:0] sch_d [int];
  logic [1:0]  msk_at [int];
  bit          mr_on = 0, mw_on = 0;
  int          mr_idx = 0, mw_idx = 0;
  logic [7:0]  mr_col = '0, mw_col = '0;

  // user beat source
  int          bidx = 0;
  logic [15:0] wbase = '0;
  logic [15:0] mask_pat = '0;
  assign beat_wdata = wbase + 16'(bidx) * 16'h0101;
  assign beat_mask  = mask_pat[2*(bidx%8) +: 2];

  always @(posedge clk) begin
    int k;
    logic [15:0] d;
    logic [1:0]  m;
    logic [7:0]  a;
    k = cnt;
    if (rst_n) begin
      if (sch_d.exists(k) && sd_dq_oe) chk(0, "R6", "DQ driven while memory drives", 1, 0);
      msk_at[k+2] = sd_dqm;
      if (sd_cmd_n == CMD_READ) begin
        mr_on = 1; mr_idx = 0; mr_col = sd_addr[7:0]; mw_on = 0;
      end else if (sd_cmd_n == CMD_WRITE) begin
        mw_on = 1; mw_idx = 0; mw_col = sd_addr[7:0]; mr_on = 0;
      end else if (sd_cmd_n == CMD_BSTOP) begin
        mr_on = 0; mw_on = 0;
      end
      if (mr_on) begin
        a = 8'(int'(mr_col) + mr_idx);
        sch_d[k+model_cl] = mem[a];
        mr_idx++;
        if ((!model_full && mr_idx == BL) || mr_idx == 256) mr_on = 0;
      end
      if (mw_on) begin
        chk(sd_dq_oe, "R7", "DQ enable on write beat", sd_dq_oe, 1);
        a = 8'(int'(mw_col) + mw_idx);
        if (!sd_dqm[0]) mem[a][7:0]  = sd_dq_out[7:0];
        if (!sd_dqm[1]) mem[a][15:8] = sd_dq_out[15:8];
        mw_idx++;
        if ((!model_full && mw_idx == BL) || mw_idx == 256) mw_on = 0;
      end
    end
    if (sch_d.exists(k+1)) begin
      d = sch_d[k+1];
      m = msk_at.exists(k+1) ? msk_at[k+1] : 2'b00;
      if (m[0]) d[7:0]  = 8'hEE;
      if (m[1]) d[15:8] = 8'hEE;
      sd_dq_in <= d;
    end else begin
      sd_dq_in <= 16'h5A5A;
    end
    if (req_valid && req_ready) bidx <= 0;
    else if (beat_req)          bidx <= bidx + 1;
    cnt = cnt + 1;
  end

  // ---------------- scoreboard ----------------
  typedef struct {
    logic [15:0] d;
    logic [1:0]  m;
    int          c;
  } rexp_t;
  rexp_t rq[$];

  int         exp_c0 = -1, exp_done = -1, exp_bst = -1, bst_seen = 0;
  bit         exp_wr = 0;
  logic [7:0] exp_col = '0;
  logic [1:0] exp_ba = '0;

  always @(negedge clk) begin
    rexp_t e;
    if (rst_n) begin
      if (rd_valid) begin
        if (rq.size() == 0) chk(0, "R3", "unexpected read beat", 1, 0);
        else begin
          e = rq.pop_front();
          if (e.m != 2'b00) chk(rd_data == e.d, "R5", "masked read data", rd_data, e.d);
          else              chk(rd_data == e.d, "R3", "read data", rd_data, e.d);
          chk(rd_masked == e.m, "R5", "masked flag", rd_masked, e.m);
          chk(cnt == e.c, "R4", "read beat cycle", cnt, e.c);
        end
      end
      if (sd_cmd_n == CMD_READ || sd_cmd_n == CMD_WRITE) begin
        chk(cnt == exp_c0, "R2", "column command cycle", cnt, exp_c0);
        chk(sd_addr == {4'b0, exp_col} && sd_ba == exp_ba, "R2", "column address",
            {sd_ba, sd_addr}, {exp_ba, 4'b0, exp_col});
        chk((sd_cmd_n == CMD_WRITE) == exp_wr, "R2", "command kind", sd_cmd_n, exp_wr);
      end
      if (sd_cmd_n == CMD_BSTOP) begin
        bst_seen++;
        chk(cnt == exp_bst, "R10", "burst stop cycle", cnt, exp_bst);
      end
      if (done) begin
        if (exp_wr) chk(cnt == exp_done, "R11", "write done cycle", cnt, exp_done);
        else begin
          chk(cnt == exp_done, "R12", "read done cycle", cnt, exp_done);
          chk(rd_valid, "R12", "done with last beat", rd_valid, 1);
        end
      end
    end
  end

  task automatic run(bit wr, logic [7:0] col, bit full, int len, bit cl3,
                     logic [15:0] mpat, logic [15:0] base);
    int n, cl;
    logic [1:0]  m;
    logic [15:0] d;
    logic [7:0]  a;
    rexp_t e;
    n  = full ? len : BL;
    cl = cl3 ? 3 : 2;
    @(negedge clk);
    model_full = full; model_cl = cl; mask_pat = mpat; wbase = base;
    req_write = wr; req_col = col; req_full_page = full; req_len = 9'(len);
    cfg_cas3 = cl3; req_bank = 2'(col[1:0]); req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    exp_c0 = cnt + 1; exp_col = col; exp_ba = 2'(col[1:0]); exp_wr = wr;
    exp_bst = full ? exp_c0 + n : -1;
    exp_done = wr ? exp_c0 + n + TWR : exp_c0 + cl + n;
    bst_seen = 0;
    for (int i = 0; i < n; i++) begin
      m = mpat[2*(i%8) +: 2];
      a = 8'(int'(col) + i);
      if (wr) begin
        d = base + 16'(i) * 16'h0101;
        if (!m[0]) ref_mem[a][7:0]  = d[7:0];
        if (!m[1]) ref_mem[a][15:8] = d[15:8];
      end else begin
        d = ref_mem[a];
        if (m[0]) d[7:0]  = 8'h00;
        if (m[1]) d[15:8] = 8'h00;
        e.d = d; e.m = m; e.c = exp_c0 + cl + i + 1;
        rq.push_back(e);
      end
    end
    @(negedge clk);
    req_valid = 1'b0;
    while (!done) @(negedge clk);
    @(negedge clk);
    chk(rq.size() == 0, "R3", "all read beats returned", rq.size(), 0);
    if (full) chk(bst_seen == 1, "R10", "burst stop count", bst_seen, 1);
    else      chk(bst_seen == 0, "R9", "no burst stop on fixed burst", bst_seen, 0);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    for (int c = 0; c < 256; c++) begin
      mem[c]     = {8'(c) ^ 8'h5A, 8'(c)};
      ref_mem[c] = mem[c];
    end
    repeat (3) @(negedge clk);
    // reset state
    chk(!req_ready && !done && !rd_valid && !sd_dq_oe, "R1", "reset outputs quiet",
        {req_ready, done, rd_valid, sd_dq_oe}, 0);
    chk(sd_cmd_n == CMD_NOP, "R2", "NOP in reset", sd_cmd_n, CMD_NOP);
    rst_n = 1'b1;
    // request while bank is closed
    req_valid = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(!req_ready, "R1", "no ready with bank inactive", req_ready, 0);
      chk(sd_cmd_n == CMD_NOP, "R1", "no command with bank inactive", sd_cmd_n, CMD_NOP);
    end
    req_valid = 1'b0;
    bank_active = 1'b1;
    @(negedge clk);
    chk(req_ready, "R1", "ready once bank active", req_ready, 1);

    // fixed write, then reads at both latencies
    run(1, 8'd8,  0, 0, 0, 16'h0000, 16'h1100);              // R7 R9 R11
    run(0, 8'd8,  0, 0, 0, 16'h0000, 16'h0000);              // R3 R4 CL2
    run(0, 8'd8,  0, 0, 1, 16'h00E4, 16'h0000);              // R4 R5 CL3
    run(0, 8'd8,  0, 0, 0, 16'h001B, 16'h0000);              // R5 CL2
    // masked write, read back
    run(1, 8'd16, 0, 0, 1, 16'h0032, 16'h2200);              // R8
    run(0, 8'd16, 0, 0, 1, 16'h0000, 16'h0000);              // R8 check
    // full page
    run(1, 8'd40, 1, 6, 0, 16'h0300, 16'h4400);              // R10 R11
    run(0, 8'd40, 1, 7, 0, 16'h1804, 16'h0000);              // R10 R5
    run(0, 8'd41, 1, 1, 1, 16'h0000, 16'h0000);              // R10 len 1
    run(1, 8'd250, 1, 7, 1, 16'h0000, 16'h6600);             // wrap in page
    run(0, 8'd250, 1, 7, 1, 16'h2001, 16'h0000);             // R6 turnaround
    run(1, 8'd0,  1, 1, 0, 16'h0000, 16'h7700);              // R11 len 1
    run(0, 8'd0,  0, 0, 1, 16'h0000, 16'h0000);
    repeat (4) @(negedge clk);
    summary();
    $finish;
  end
endmodule